// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the type-0 configuration header of a bridge endpoint and serves it to two requesters at once: a remote port driven by the host on the PCI side and a local port driven by the processor bus. Each port presents a valid strobe, a write flag, a dword index, four byte enables and write data. It receives combinational read data for the addressed dword in the same cycle. Writes take effect at the next rising clock edge. The identity fields are fixed at elaboration time. The command, status, latency timer and up to three memory base address registers are held in flops.

The two ports do not have equal authority. The remote host stores exactly what it writes, subject to byte enables, the implemented-bit masks and the aperture size of each base address register. Any local write to the command dword instead switches on every implemented command enable. Any local write to the dword holding the latency timer loads the timer with its maximum value. When both ports write the same register in the same cycle, the remote write wins.

A gate output allows outbound configuration cycles toward remote devices only once bus mastering is enabled and the latency timer is nonzero. While the gate is closed, an outbound read completes at once with all-ones data, and an outbound write is refused.

Top module: `cfg_header_regs`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {CLASS_CODE, REV_ID}. Dword 11 reads {SUBSYS_ID, SUBSYS_VENDOR_ID}. Dword 15 bits [31:24] read MAX_LAT and bits [23:16] read MIN_GNT. Writes from either port never change these fields.
- R2: Dword 3 bits [31:16] (self-test and header type) read 0x0000 and bits [7:0] (line size) read 0x00. Dword 15 bits [15:8] (interrupt pin) read 0x01 and bits [7:0] read 0x00. Dwords 7 to 10 and 12 to 14 read zero.
- R3: Base address register n lives at dword 4+n. When n is at or above BAR_NUM (0 to 3), or when n is 3, 4 or 5, it reads zero and writes to it have no effect.
- R4: An implemented base address register n reads bits below BARn_LOG2 as zero. Its bits [3:0] read 0000, meaning 32-bit, non-prefetchable, memory space. Writing all ones therefore reads back ~(2^BARn_LOG2 - 1).
- R5: A remote write stores the enabled bytes. For command (dword 1 bits [15:0], implemented bits mask 0x0146: bit 1 memory, bit 2 bus master, bit 6 parity response, bit 8 system error), the enable is byte enables 0 and 1. For the latency timer (dword 3 bits [15:8]), the enable is byte enable 1. For base address registers, all four byte enables apply. Disabled bytes keep their value.
- R6: Any local write to dword 1, whatever its data and byte enables, sets command to 0x0146 and leaves status unchanged.
- R7: Any local write to dword 3, whatever its data and byte enables, sets the latency timer to 0xFF.
- R8: Status (dword 1 bits [31:16]) implements only the error bits in mask 0xF900. A bit of errSet inside that mask sets the matching bit. A remote write with byte enable 3 clears the bits written as one. A set and a clear of the same bit in the same cycle leave it set. Local writes never clear status.
- R9: obAllow is high exactly when command bit 2 is set and the latency timer is nonzero.
- R10: An outbound read (obReq high, obWrite low) raises obDone in the same cycle. obRdData is obRemoteData when obAllow is high and 0xFFFFFFFF otherwise.
- R11: An outbound write raises obDone when obAllow is high. Otherwise it raises obAbort and leaves obDone low.
- R12: Dword indices 16 to 63 read zero, and writes to them change no register.
- R13: When both ports write the same register in the same cycle, the stored value is the remote port's.
- R14: A port's read data is zero unless that port has valid high and write low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| remValid | input | 1 | Remote access strobe |
| remWrite | input | 1 | Remote access is a write |
| remIndex | input | 6 | Remote dword index |
| remByteEn | input | 4 | Remote byte enables |
| remWrData | input | 32 | Remote write data |
| remRdData | output | 32 | Remote read data, combinational |
| locValid | input | 1 | Local access strobe |
| locWrite | input | 1 | Local access is a write |
| locIndex | input | 6 | Local dword index |
| locByteEn | input | 4 | Local byte enables |
| locWrData | input | 32 | Local write data |
| locRdData | output | 32 | Local read data, combinational |
| errSet | input | 16 | Status error set pulses, masked by 0xF900 |
| obReq | input | 1 | Outbound configuration request |
| obWrite | input | 1 | Outbound request is a write |
| obRemoteData | input | 32 | Data returned by the remote device |
| obAllow | output | 1 | Outbound configuration permitted |
| obDone | output | 1 | Outbound request completed |
| obAbort | output | 1 | Outbound write refused |
| obRdData | output | 32 | Outbound read result |

## Verification
The bench builds the block with BAR_NUM = 2, a 16-byte first aperture (BAR0_LOG2 = 4, the smallest legal size), a 4 KiB second aperture, and an unused third size parameter. This single build covers an implemented register at the minimum size, an implemented register with many masked bits, and an unimplemented register that still has a size parameter. After reset, all 64 dword indices are swept from both ports. All 16 byte-enable patterns are then swept over the command, latency timer and base address registers, with expected values computed from masks. The outbound gate is checked over every combination of bus master enable and a zero, small or large latency timer.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int IDX_W = 6;
  localparam int MAX_BARS = 3;
  localparam int HDR_DWORDS = 16;
  localparam int CMD_MASTER_BIT = 2;
  localparam logic [15:0] CMD_IMPL_MASK = 16'h0146;
  localparam logic [15:0] STAT_ERR_MASK = 16'hF900;
  localparam logic [7:0] INT_PIN_VALUE = 8'h01;

  localparam logic [IDX_W-1:0] IDX_IDENT = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMDSTAT = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
  localparam logic [IDX_W-1:0] IDX_TIMING = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BAR0 = 6'd4;
  localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'd11;
  localparam logic [IDX_W-1:0] IDX_INTR = 6'd15;

  typedef struct packed {
    logic remCmdLo;
    logic remCmdHi;
    logic remStatLo;
    logic remStatHi;
    logic remLat;
    logic [MAX_BARS-1:0] remBar;
    logic locCmd;
    logic locLat;
    logic [MAX_BARS-1:0] locBar;
  } wrStrobe_t;

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldWord,
                                             input logic [31:0] newWord,
                                             input logic [3:0] byteEn);
    logic [31:0] res;
    res = oldWord;
    for (int b = 0; b < 4; b++) begin
      if (byteEn[b]) res[b*8 +: 8] = newWord[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int BAR_NUM = 3
) (
  input  logic             remValid,
  input  logic             remWrite,
  input  logic [IDX_W-1:0] remIndex,
  input  logic [3:0]       remByteEn,
  input  logic             locValid,
  input  logic             locWrite,
  input  logic [IDX_W-1:0] locIndex,
  input  logic             masterEn,
  input  logic [7:0]       latTimer,
  input  logic             obReq,
  input  logic             obWrite,
  input  logic [31:0]      obRemoteData,
  output wrStrobe_t        stb,
  output logic             obAllow,
  output logic             obDone,
  output logic             obAbort,
  output logic [31:0]      obRdData
);
  logic remWe;
  logic locWe;

  assign remWe = remValid && remWrite;
  assign locWe = locValid && locWrite;

  always_comb begin
    stb = '0;
    stb.remCmdLo  = remWe && (remIndex == IDX_CMDSTAT) && remByteEn[0];
    stb.remCmdHi  = remWe && (remIndex == IDX_CMDSTAT) && remByteEn[1];
    stb.remStatLo = remWe && (remIndex == IDX_CMDSTAT) && remByteEn[2];
    stb.remStatHi = remWe && (remIndex == IDX_CMDSTAT) && remByteEn[3];
    stb.remLat    = remWe && (remIndex == IDX_TIMING) && remByteEn[1];
    stb.locCmd    = locWe && (locIndex == IDX_CMDSTAT);
    stb.locLat    = locWe && (locIndex == IDX_TIMING);
    for (int i = 0; i < MAX_BARS; i++) begin
      stb.remBar[i] = remWe && (remIndex == IDX_BAR0 + IDX_W'(i)) && (i < BAR_NUM);
      stb.locBar[i] = locWe && (locIndex == IDX_BAR0 + IDX_W'(i)) && (i < BAR_NUM);
    end
  end

  // Outbound gate: mastering on and a nonzero timer.
  assign obAllow = masterEn && (latTimer != 8'h00);
  assign obDone  = obReq && (obAllow || !obWrite);
  assign obAbort = obReq && obWrite && !obAllow;

  always_comb begin
    obRdData = '0;
    if (obReq && !obWrite) obRdData = obAllow ? obRemoteData : 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/cfg_hdr_dp.sv
module cfg_hdr_dp
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID        = 16'h0001,
  parameter logic [15:0] VENDOR_ID        = 16'h0001,
  parameter logic [23:0] CLASS_CODE       = 24'h068000,
  parameter logic [7:0]  REV_ID           = 8'h00,
  parameter logic [15:0] SUBSYS_ID        = 16'h0000,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
  parameter logic [7:0]  MAX_LAT          = 8'h00,
  parameter logic [7:0]  MIN_GNT          = 8'h00,
  parameter int          BAR_NUM          = 3,
  parameter int          BAR0_LOG2        = 16,
  parameter int          BAR1_LOG2        = 16,
  parameter int          BAR2_LOG2        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        stb,
  input  logic             remValid,
  input  logic             remWrite,
  input  logic [IDX_W-1:0] remIndex,
  input  logic [3:0]       remByteEn,
  input  logic [31:0]      remWrData,
  input  logic             locValid,
  input  logic             locWrite,
  input  logic [IDX_W-1:0] locIndex,
  input  logic [3:0]       locByteEn,
  input  logic [31:0]      locWrData,
  input  logic [15:0]      errSet,
  output logic             masterEn,
  output logic [15:0]      cmdBits,
  output logic [7:0]       latTimer,
  output logic [31:0]      remRdData,
  output logic [31:0]      locRdData
);
  localparam int BAR_LOG2 [MAX_BARS] = '{BAR0_LOG2, BAR1_LOG2, BAR2_LOG2};

  logic [15:0] cmdQ;
  logic [15:0] statQ;
  logic [7:0]  latQ;
  logic [15:0] cmdNext;
  logic [15:0] statClr;
  logic [31:0] barVal [MAX_BARS];
  logic [31:0] hdrWords [HDR_DWORDS];

  // Command: remote bytes win over a local force.
  assign cmdNext = {stb.remCmdHi ? remWrData[15:8] : cmdQ[15:8],
                    stb.remCmdLo ? remWrData[7:0]  : cmdQ[7:0]} & CMD_IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) cmdQ <= '0;
    else if (stb.remCmdLo || stb.remCmdHi) cmdQ <= cmdNext;
    else if (stb.locCmd) cmdQ <= CMD_IMPL_MASK;
  end

  // Status: write-one-to-clear from the remote port, sets take precedence.
  assign statClr = {stb.remStatHi ? remWrData[31:24] : 8'h00,
                    stb.remStatLo ? remWrData[23:16] : 8'h00} & STAT_ERR_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else statQ <= (statQ & ~statClr) | (errSet & STAT_ERR_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) latQ <= '0;
    else if (stb.remLat) latQ <= remWrData[15:8];
    else if (stb.locLat) latQ <= 8'hFF;
  end

  for (genvar g = 0; g < MAX_BARS; g++) begin : g_bar
    if (g < BAR_NUM) begin : g_impl
      localparam logic [31:0] KEEP = ~((32'd1 << BAR_LOG2[g]) - 32'd1);
      logic [31:0] barQ;
      always_ff @(posedge clk) begin
        if (!rstN) barQ <= '0;
        else if (stb.remBar[g]) barQ <= mergeBytes(barQ, remWrData, remByteEn) & KEEP;
        else if (stb.locBar[g]) barQ <= mergeBytes(barQ, locWrData, locByteEn) & KEEP;
      end
      assign barVal[g] = barQ;
    end else begin : g_none
      assign barVal[g] = '0;
    end
  end

  always_comb begin
    for (int w = 0; w < HDR_DWORDS; w++) hdrWords[w] = '0;
    hdrWords[IDX_IDENT[3:0]]   = {DEVICE_ID, VENDOR_ID};
    hdrWords[IDX_CMDSTAT[3:0]] = {statQ, cmdQ};
    hdrWords[IDX_CLASS[3:0]]   = {CLASS_CODE, REV_ID};
    hdrWords[IDX_TIMING[3:0]]  = {16'h0000, latQ, 8'h00};
    for (int i = 0; i < MAX_BARS; i++) hdrWords[IDX_BAR0[3:0] + 4'(i)] = barVal[i];
    hdrWords[IDX_SUBSYS[3:0]]  = {SUBSYS_ID, SUBSYS_VENDOR_ID};
    hdrWords[IDX_INTR[3:0]]    = {MAX_LAT, MIN_GNT, INT_PIN_VALUE, 8'h00};
  end

  assign remRdData = (remValid && !remWrite && (remIndex < IDX_W'(HDR_DWORDS)))
                     ? hdrWords[remIndex[3:0]] : 32'h0;
  assign locRdData = (locValid && !locWrite && (locIndex < IDX_W'(HDR_DWORDS)))
                     ? hdrWords[locIndex[3:0]] : 32'h0;

  assign masterEn = cmdQ[CMD_MASTER_BIT];
  assign cmdBits  = cmdQ;
  assign latTimer = latQ;
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID        = 16'h0001,
  parameter logic [15:0] VENDOR_ID        = 16'h0001,
  parameter logic [23:0] CLASS_CODE       = 24'h068000,
  parameter logic [7:0]  REV_ID           = 8'h00,
  parameter logic [15:0] SUBSYS_ID        = 16'h0000,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
  parameter logic [7:0]  MAX_LAT          = 8'h00,
  parameter logic [7:0]  MIN_GNT          = 8'h00,
  parameter int          BAR_NUM          = 3,
  parameter int          BAR0_LOG2        = 16,
  parameter int          BAR1_LOG2        = 16,
  parameter int          BAR2_LOG2        = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        remValid,
  input  logic        remWrite,
  input  logic [5:0]  remIndex,
  input  logic [3:0]  remByteEn,
  input  logic [31:0] remWrData,
  output logic [31:0] remRdData,
  input  logic        locValid,
  input  logic        locWrite,
  input  logic [5:0]  locIndex,
  input  logic [3:0]  locByteEn,
  input  logic [31:0] locWrData,
  output logic [31:0] locRdData,
  input  logic [15:0] errSet,
  input  logic        obReq,
  input  logic        obWrite,
  input  logic [31:0] obRemoteData,
  output logic        obAllow,
  output logic        obDone,
  output logic        obAbort,
  output logic [31:0] obRdData
);
  wrStrobe_t   stb;
  logic        masterEn;
  logic [15:0] cmdBits;
  logic [7:0]  latTimer;

  cfg_hdr_ctrl #(.BAR_NUM(BAR_NUM)) ctrl_i (
    .remValid(remValid), .remWrite(remWrite), .remIndex(remIndex), .remByteEn(remByteEn),
    .locValid(locValid), .locWrite(locWrite), .locIndex(locIndex),
    .masterEn(masterEn), .latTimer(latTimer),
    .obReq(obReq), .obWrite(obWrite), .obRemoteData(obRemoteData),
    .stb(stb), .obAllow(obAllow), .obDone(obDone), .obAbort(obAbort), .obRdData(obRdData)
  );

  cfg_hdr_dp #(
    .DEVICE_ID(DEVICE_ID), .VENDOR_ID(VENDOR_ID), .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID),
    .SUBSYS_ID(SUBSYS_ID), .SUBSYS_VENDOR_ID(SUBSYS_VENDOR_ID),
    .MAX_LAT(MAX_LAT), .MIN_GNT(MIN_GNT), .BAR_NUM(BAR_NUM),
    .BAR0_LOG2(BAR0_LOG2), .BAR1_LOG2(BAR1_LOG2), .BAR2_LOG2(BAR2_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .remValid(remValid), .remWrite(remWrite), .remIndex(remIndex),
    .remByteEn(remByteEn), .remWrData(remWrData),
    .locValid(locValid), .locWrite(locWrite), .locIndex(locIndex),
    .locByteEn(locByteEn), .locWrData(locWrData),
    .errSet(errSet), .masterEn(masterEn), .cmdBits(cmdBits), .latTimer(latTimer),
    .remRdData(remRdData), .locRdData(locRdData)
  );
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        remValid,
  input logic        remWrite,
  input logic [5:0]  remIndex,
  input logic [3:0]  remByteEn,
  input logic [31:0] remRdData,
  input logic        locValid,
  input logic        locWrite,
  input logic [5:0]  locIndex,
  input logic        obReq,
  input logic        obWrite,
  input logic        obAllow,
  input logic        obDone,
  input logic        obAbort,
  input logic [31:0] obRdData,
  input logic [15:0] cmdBits,
  input logic [7:0]  latTimer
);
  logic remCmdWr;
  logic remLatWr;
  assign remCmdWr = remValid && remWrite && (remIndex == 6'd1) && (remByteEn[1:0] != 2'b00);
  assign remLatWr = remValid && remWrite && (remIndex == 6'd3) && remByteEn[1];

  AST_LOC_CMD_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locWrite && locIndex == 6'd1 && !remCmdWr) |=> (cmdBits == 16'h0146)); // R6

  AST_LOC_LAT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locWrite && locIndex == 6'd3 && !remLatWr) |=> (latTimer == 8'hFF)); // R7

  AST_OB_READ_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (obReq && !obWrite && !obAllow) |-> (obDone && obRdData == 32'hFFFF_FFFF)); // R10

  AST_OB_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (obReq && obWrite && !obAllow) |-> (obAbort && !obDone)); // R11

  AST_HIGH_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (remValid && !remWrite && remIndex >= 6'd16) |-> (remRdData == 32'h0)); // R12

  AST_INT_PIN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (remValid && !remWrite && remIndex == 6'd15) |-> (remRdData[15:8] == 8'h01)); // R2

  AST_HDR_TYPE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (remValid && !remWrite && remIndex == 6'd3) |-> (remRdData[31:16] == 16'h0000)); // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!remValid || remWrite) |-> (remRdData == 32'h0)); // R14
endmodule

bind cfg_header_regs cfg_header_regs_chk chk_i (
  .clk(clk), .rstN(rstN), .remValid(remValid), .remWrite(remWrite), .remIndex(remIndex),
  .remByteEn(remByteEn), .remRdData(remRdData), .locValid(locValid), .locWrite(locWrite),
  .locIndex(locIndex), .obReq(obReq), .obWrite(obWrite), .obAllow(obAllow),
  .obDone(obDone), .obAbort(obAbort), .obRdData(obRdData),
  .cmdBits(cmdBits), .latTimer(latTimer)
);

// File: tb/cfg_header_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_header_regs_tb_top;
  localparam logic [15:0] P_DEV = 16'h7A31;
  localparam logic [15:0] P_VEN = 16'h13C5;
  localparam logic [23:0] P_CLS = 24'h0B4000;
  localparam logic [7:0]  P_REV = 8'h02;
  localparam logic [15:0] P_SID = 16'h0102;
  localparam logic [15:0] P_SVN = 16'h4D21;
  localparam logic [7:0]  P_MLT = 8'h10;
  localparam logic [7:0]  P_MGN = 8'h04;
  localparam int P_BARS = 2;
  localparam int P_LOG2 [3] = '{4, 12, 8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic remValid = 0, remWrite = 0, locValid = 0, locWrite = 0;
  logic [5:0] remIndex = 0, locIndex = 0;
  logic [3:0] remByteEn = 0, locByteEn = 0;
  logic [31:0] remWrData = 0, locWrData = 0, obRemoteData = 32'h1234_5678;
  logic [15:0] errSet = 0;
  logic obReq = 0, obWrite = 0;
  logic [31:0] remRdData, locRdData, obRdData;
  logic obAllow, obDone, obAbort;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] mCmd = 0, mStat = 0;
  logic [7:0] mLat = 0;
  logic [31:0] mBar [3] = '{default: 0};

  always #2.5 clk = ~clk;

  cfg_header_regs #(
    .DEVICE_ID(P_DEV), .VENDOR_ID(P_VEN), .CLASS_CODE(P_CLS), .REV_ID(P_REV),
    .SUBSYS_ID(P_SID), .SUBSYS_VENDOR_ID(P_SVN), .MAX_LAT(P_MLT), .MIN_GNT(P_MGN),
    .BAR_NUM(P_BARS), .BAR0_LOG2(P_LOG2[0]), .BAR1_LOG2(P_LOG2[1]), .BAR2_LOG2(P_LOG2[2])
  ) dut_i (.*);

  function automatic logic [31:0] keepMask(input int n);
    if (n >= P_BARS) return 32'h0;
    return ~((32'd1 << P_LOG2[n]) - 32'd1);
  endfunction

  function automatic logic [31:0] expWord(input int idx);
    case (idx)
      0: return {P_DEV, P_VEN};
      1: return {mStat, mCmd};
      2: return {P_CLS, P_REV};
      3: return {16'h0, mLat, 8'h0};
      4, 5, 6: return mBar[idx-4];
      11: return {P_SID, P_SVN};
      15: return {P_MLT, P_MGN, 8'h01, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input int idx);
    if (idx >= 16) return "R12";
    if (idx == 0 || idx == 2 || idx == 11) return "R1";
    if (idx >= 4 && idx <= 9) return "R3";
    return "R2";
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelRem(input int idx, input logic [3:0] be, input logic [31:0] d);
    if (idx == 1) begin
      if (be[0]) mCmd[7:0] = d[7:0] & 8'h46;
      if (be[1]) mCmd[15:8] = d[15:8] & 8'h01;
      if (be[3]) mStat[15:8] = mStat[15:8] & ~d[31:24];
    end else if (idx == 3) begin
      if (be[1]) mLat = d[15:8];
    end else if (idx >= 4 && idx <= 6) begin
      mBar[idx-4] = merge(mBar[idx-4], d, be) & keepMask(idx-4);
    end
  endtask

  task automatic modelLoc(input int idx, input logic [3:0] be, input logic [31:0] d);
    if (idx == 1) mCmd = 16'h0146;
    else if (idx == 3) mLat = 8'hFF;
    else if (idx >= 4 && idx <= 6) mBar[idx-4] = merge(mBar[idx-4], d, be) & keepMask(idx-4);
  endtask

  task automatic remWr(input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    remValid = 1; remWrite = 1; remIndex = 6'(idx); remByteEn = be; remWrData = d;
    @(negedge clk);
    remValid = 0; remWrite = 0;
    modelRem(idx, be, d);
  endtask

  task automatic locWr(input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    locValid = 1; locWrite = 1; locIndex = 6'(idx); locByteEn = be; locWrData = d;
    @(negedge clk);
    locValid = 0; locWrite = 0;
    modelLoc(idx, be, d);
  endtask

  task automatic bothWr(input int idx, input logic [31:0] rd, input logic [31:0] ld);
    @(negedge clk);
    remValid = 1; remWrite = 1; remIndex = 6'(idx); remByteEn = 4'hF; remWrData = rd;
    locValid = 1; locWrite = 1; locIndex = 6'(idx); locByteEn = 4'hF; locWrData = ld;
    @(negedge clk);
    remValid = 0; remWrite = 0; locValid = 0; locWrite = 0;
    modelLoc(idx, 4'hF, ld);
    modelRem(idx, 4'hF, rd);
  endtask

  task automatic rdBoth(input int idx, input string req);
    @(negedge clk);
    remValid = 1; remWrite = 0; remIndex = 6'(idx);
    locValid = 1; locWrite = 0; locIndex = 6'(idx);
    #1;
    check(req, remRdData, expWord(idx));
    check(req, locRdData, expWord(idx));
    remValid = 0; locValid = 0;
  endtask

  task automatic obCheck();
    logic allow;
    allow = mCmd[2] && (mLat != 0);
    @(negedge clk);
    obReq = 1; obWrite = 0;
    #1;
    check("R9", {31'h0, obAllow}, {31'h0, allow});
    check("R10", {31'h0, obDone}, 32'h1);
    check("R10", obRdData, allow ? obRemoteData : 32'hFFFF_FFFF);
    obWrite = 1;
    #1;
    check("R11", {30'h0, obDone, obAbort}, allow ? 32'h2 : 32'h1);
    obReq = 0; obWrite = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;

    // Reset state and fixed fields over every index (R1, R2, R3, R12)
    for (int i = 0; i < 64; i++) rdBoth(i, reqOf(i));
    obCheck();

    // R14: no read data without a read
    @(negedge clk); #1;
    check("R14", remRdData, 32'h0);
    locValid = 1; locWrite = 1; locIndex = 6'd0; locByteEn = 4'h0;
    #1;
    check("R14", locRdData, 32'h0);
    locValid = 0; locWrite = 0;

    // R5: byte enable sweep on command, latency timer, base address 1
    for (int be = 0; be < 16; be++) begin
      remWr(1, 4'(be), 32'h0000_FFFF ^ (32'(be) * 32'h0000_0111));
      rdBoth(1, "R5");
      remWr(3, 4'(be), {8'hAA, 8'h55, 8'(be * 17 + 1), 8'hC3});
      rdBoth(3, "R5");
      remWr(5, 4'(be), 32'hDEAD_BEEF ^ (32'(be) << 20));
      rdBoth(5, "R5");
    end

    // R4 / R3: all-ones write reveals aperture; unimplemented stays zero
    for (int n = 0; n < 6; n++) begin
      remWr(4 + n, 4'hF, 32'hFFFF_FFFF);
      rdBoth(4 + n, n < P_BARS ? "R4" : "R3");
      locWr(4 + n, 4'hF, 32'hFFFF_FFFF);
      rdBoth(4 + n, n < P_BARS ? "R4" : "R3");
    end

    // R8: set all error bits, clear them one at a time
    @(negedge clk); errSet = 16'hFFFF; @(negedge clk); errSet = 16'h0;
    mStat = mStat | 16'hF900;
    rdBoth(1, "R8");
    // R6: local force leaves status alone
    remWr(1, 4'h3, 32'h0);
    locWr(1, 4'h0, 32'hFFFF_FFFF);
    rdBoth(1, "R6");
    // R7: local latency force
    remWr(3, 4'h2, 32'h0);
    locWr(3, 4'h0, 32'h0);
    rdBoth(3, "R7");
    foreach (P_LOG2[k]) begin end
    for (int b = 8; b < 16; b++) begin
      remWr(1, 4'h8, 32'(1) << (b + 16));
      rdBoth(1, "R8");
    end
    // R8: simultaneous set and clear keeps bit set
    @(negedge clk);
    errSet = 16'h8000;
    remValid = 1; remWrite = 1; remIndex = 6'd1; remByteEn = 4'h8; remWrData = 32'h8000_0000;
    @(negedge clk);
    errSet = 16'h0; remValid = 0; remWrite = 0;
    mStat = mStat | 16'h8000;
    rdBoth(1, "R8");

    // R12: writes to aliases above the header change nothing
    remWr(1, 4'hF, 32'h0);
    remWr(3, 4'hF, 32'h0);
    @(negedge clk);
    remValid = 1; remWrite = 1; remIndex = 6'd17; remByteEn = 4'hF; remWrData = 32'h0000_FFFF;
    locValid = 1; locWrite = 1; locIndex = 6'd19; locByteEn = 4'hF; locWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    remValid = 0; remWrite = 0; locValid = 0; locWrite = 0;
    rdBoth(1, "R12");
    rdBoth(3, "R12");

    // R13: remote wins a same-cycle collision
    bothWr(1, 32'h0000_0002, 32'h0);
    rdBoth(1, "R13");
    bothWr(3, 32'h0000_0700, 32'h0);
    rdBoth(3, "R13");
    bothWr(4, 32'h1234_5670, 32'hFFFF_FFFF);
    rdBoth(4, "R13");

    // R9, R10, R11: gate over master enable and timer values
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 3; t++) begin
        remWr(1, 4'h1, m ? 32'h4 : 32'h0);
        remWr(3, 4'h2, {16'h0, (t == 0) ? 8'h00 : (t == 1) ? 8'h01 : 8'h80, 8'h0});
        obRemoteData = 32'hC0DE_0000 + 32'(m * 4 + t);
        obCheck();
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule